// File: doc/BRIEF.md
# I2C Request Engine with Register Front End

This block runs one I2C request at a time for a host that programs a small register bank and cannot wait on a stretched clock. The host writes a command code, a 7-bit target address, a byte count of 0 to 16 and, for writes, the outgoing bytes. It then sets a send bit. The engine sequences a start-type condition, the address byte, the data bytes and, for closing commands, a stop. It drives these over a byte-level link interface built on a request/response handshake, so bit timing stays in a separate link layer.

A request can leave the bus held open, so a series of requests can form one bus transaction. Examples are a zero-length write to claim a target, a one-byte offset write, and several 16-byte reads that finish with a closing zero-length read. When the request ends, the engine clears the send bit itself. It then posts a sticky completion flag and reports failures: a target that refuses its address, a target that refuses a data byte partway through, and an unsupported command code. The interrupt line is gated by two enables.

Register map (byte-wide, 6-bit offset): 0x00 command [3:0]; 0x01 target address [6:0]; 0x02 byte count [4:0]; 0x03 control (bit0 send, bit1 completion-interrupt enable, bit2 global interrupt enable); 0x04 status (bit0 completion, bit1 failed, bit2 short transfer; writing 1 clears a bit); 0x10-0x1F outgoing bytes; 0x20-0x2F received bytes (read only). Link operation codes on `lnk_op`: 0 start, 1 repeated start, 2 write byte, 3 read byte, 4 stop.

Top module: `i2creq_engine`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `lnk_req` is low.
- R2: Command bit 0 selects read (1) or write (0), and bit 2 selects keep-open (1) or close (0), so 0x0, 0x1, 0x4 and 0x5 are valid. Any command with bit 1 or bit 3 set sets the failed flag and completes without any link request, and it leaves the open-transaction state unchanged.
- R3: A request starts with op 0 (start) when no transaction is open, or when the address or direction differs from the open one. Otherwise it starts with op 1 (repeated start). Either is followed by op 2 carrying {address, read bit}.
- R4: A byte count of 0 runs only the start condition and address phase, plus a stop when closing. Writes of a count above 16 store 16.
- R5: Writes send outgoing bytes 0..N-1 in order with op 2. Reads issue N op-3 transfers and store byte i in received register i. Each read carries master-ACK (`lnk_mack`=1) except the last byte of a closing read, which carries 0.
- R6: A closing command that succeeds ends with op 4 (stop) and leaves no transaction open. A keep-open command issues no stop.
- R7: If the address byte is refused (`lnk_nack`), the failed flag sets, no data op follows, and a stop is issued that closes the transaction.
- R8: If outgoing data byte i (counting from 0) is refused, the short flag sets, the count register becomes i (the number of accepted bytes), and a stop follows at once.
- R9: Writing control bit 0 as 1 sets send. The engine clears send when the request ends, and on that same edge it sets the sticky completion flag. Status bits clear only when 1 is written to them.
- R10: `irq` is high exactly when the completion flag and both enables are set.
- R11: While send is 1, writes to the command, address, count and outgoing-byte registers have no effect.
- R12: While `lnk_req` is high and `lnk_done` has not arrived, `lnk_op` and `lnk_wbyte` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Gated completion interrupt |
| lnk_req | output | 1 | Link operation requested |
| lnk_op | output | 3 | Link operation code |
| lnk_wbyte | output | 8 | Byte to send for op 2 |
| lnk_mack | output | 1 | ACK to return for op 3 |
| lnk_done | input | 1 | Link operation finished (one-cycle pulse) |
| lnk_nack | input | 1 | Target refused the byte, valid with `lnk_done` on op 2 |
| lnk_rbyte | input | 8 | Received byte, valid with `lnk_done` on op 3 |

## Verification
The hardest case to reach from the ports is the choice between start and repeated start. It depends on state left behind by earlier requests: whether a transaction is still open, and with which address and direction. The stimulus sweeps every byte count through a fixed five-command chain of open-write, open-write, open-read, close-read and close-write, so every transition between open states occurs at every length. It then places unsupported commands and an address refusal between open requests to show that the first leaves the open state alone while the second closes it. A link model with varying latency refuses chosen bytes, and a bench model predicts the full operation stream of every request.

// File: rtl/i2creq_pkg.sv
package i2creq_pkg;

   typedef enum logic [2:0] {
      LK_START  = 3'd0,
      LK_RSTART = 3'd1,
      LK_WRITE  = 3'd2,
      LK_READ   = 3'd3,
      LK_STOP   = 3'd4
   } link_op_e;

   localparam int RA_CMD   = 'h00;
   localparam int RA_TADDR = 'h01;
   localparam int RA_LEN   = 'h02;
   localparam int RA_CTRL  = 'h03;
   localparam int RA_STAT  = 'h04;
   localparam int RA_WBASE = 'h10;
   localparam int RA_RBASE = 'h20;

endpackage

// File: rtl/i2creq_regs.sv
module i2creq_regs
   import i2creq_pkg::*;
#(
   parameter int NBYTES = 16,
   parameter int AW     = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [AW-1:0]          reg_addr,
   input  logic [7:0]             reg_wdata,
   output logic [7:0]             reg_rdata,
   output logic                   send,
   output logic [3:0]             cmd,
   output logic [6:0]             taddr,
   output logic [$clog2(NBYTES+1)-1:0] len,
   output logic [NBYTES-1:0][7:0] wbuf,
   input  logic                   done,
   input  logic                   fail_set,
   input  logic                   short_set,
   input  logic [$clog2(NBYTES+1)-1:0] short_len,
   input  logic                   rd_we,
   input  logic [$clog2(NBYTES)-1:0] rd_idx,
   input  logic [7:0]             rd_byte,
   output logic                   irq
);
   localparam int LW = $clog2(NBYTES+1);
   localparam int IW = $clog2(NBYTES);

   logic       sie_q, gie_q, int_q, fail_q, short_q;
   logic [7:0] rbuf [NBYTES];
   logic       w_win, r_win, hit_cmd, hit_taddr, hit_len, hit_ctrl, hit_stat;
   logic [LW-1:0] len_in;

   assign hit_cmd   = reg_addr == AW'(RA_CMD);
   assign hit_taddr = reg_addr == AW'(RA_TADDR);
   assign hit_len   = reg_addr == AW'(RA_LEN);
   assign hit_ctrl  = reg_addr == AW'(RA_CTRL);
   assign hit_stat  = reg_addr == AW'(RA_STAT);
   assign w_win     = reg_addr[AW-1:IW] == (AW-IW)'(RA_WBASE >> IW);
   assign r_win     = reg_addr[AW-1:IW] == (AW-IW)'(RA_RBASE >> IW);
   assign len_in    = (reg_wdata > 8'(NBYTES)) ? LW'(NBYTES) : reg_wdata[LW-1:0];

   // configuration registers, locked while a request is in flight
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd   <= '0;
         taddr <= '0;
         len   <= '0;
      end else begin
         if (reg_we && !send) begin
            if (hit_cmd)   cmd   <= reg_wdata[3:0];
            if (hit_taddr) taddr <= reg_wdata[6:0];
            if (hit_len)   len   <= len_in;
         end
         if (done && short_set) len <= short_len;
      end
   end

   // control and sticky status; a set from the engine wins over a host clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         send    <= 1'b0;
         sie_q   <= 1'b0;
         gie_q   <= 1'b0;
         int_q   <= 1'b0;
         fail_q  <= 1'b0;
         short_q <= 1'b0;
      end else begin
         if (reg_we && hit_ctrl) begin
            sie_q <= reg_wdata[1];
            gie_q <= reg_wdata[2];
            if (reg_wdata[0]) send <= 1'b1;
         end
         if (reg_we && hit_stat) begin
            if (reg_wdata[0]) int_q   <= 1'b0;
            if (reg_wdata[1]) fail_q  <= 1'b0;
            if (reg_wdata[2]) short_q <= 1'b0;
         end
         if (done) begin
            send  <= 1'b0;
            int_q <= 1'b1;
            if (fail_set)  fail_q  <= 1'b1;
            if (short_set) short_q <= 1'b1;
         end
      end
   end

   // byte buffers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NBYTES; b++) begin
            wbuf[b] <= '0;
            rbuf[b] <= '0;
         end
      end else begin
         for (int b = 0; b < NBYTES; b++) begin
            if (reg_we && !send && w_win && reg_addr[IW-1:0] == IW'(b)) wbuf[b] <= reg_wdata;
            if (rd_we && rd_idx == IW'(b)) rbuf[b] <= rd_byte;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit_cmd)        reg_rdata = {4'b0, cmd};
      else if (hit_taddr) reg_rdata = {1'b0, taddr};
      else if (hit_len)   reg_rdata = 8'(len);
      else if (hit_ctrl)  reg_rdata = {5'b0, gie_q, sie_q, send};
      else if (hit_stat)  reg_rdata = {5'b0, short_q, fail_q, int_q};
      else if (w_win)     reg_rdata = wbuf[reg_addr[IW-1:0]];
      else if (r_win)     reg_rdata = rbuf[reg_addr[IW-1:0]];
   end

   assign irq = int_q & sie_q & gie_q;

   // R9: completion flag is present whenever send drops
   a_r9_int_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(send) |-> int_q);

   // R11: locked configuration while busy
   a_r11_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (send && reg_we && (hit_cmd || hit_taddr)) |=> ($stable(cmd) && $stable(taddr)));

endmodule

// File: rtl/i2creq_seq.sv
module i2creq_seq
   import i2creq_pkg::*;
#(
   parameter int NBYTES = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   send,
   input  logic [3:0]             cmd,
   input  logic [6:0]             taddr,
   input  logic [$clog2(NBYTES+1)-1:0] len,
   input  logic [NBYTES-1:0][7:0] wbuf,
   output logic                   done,
   output logic                   fail_set,
   output logic                   short_set,
   output logic [$clog2(NBYTES+1)-1:0] short_len,
   output logic                   rd_we,
   output logic [$clog2(NBYTES)-1:0] rd_idx,
   output logic [7:0]             rd_byte,
   output logic                   lnk_req,
   output logic [2:0]             lnk_op,
   output logic [7:0]             lnk_wbyte,
   output logic                   lnk_mack,
   input  logic                   lnk_done,
   input  logic                   lnk_nack,
   input  logic [7:0]             lnk_rbyte
);
   localparam int LW = $clog2(NBYTES+1);
   localparam int IW = $clog2(NBYTES);

   typedef enum logic [2:0] {S_IDLE, S_COND, S_ADDR, S_DATA, S_STOP, S_DONE} st_e;

   st_e       state;
   logic [LW-1:0] idx;
   logic      open_q, open_rd;
   logic [6:0] open_addr;
   logic      fail_r, short_r;
   logic      bad, rdir, closing, fresh, last;
   link_op_e  op;

   assign bad     = cmd[3] | cmd[1];
   assign rdir    = cmd[0];
   assign closing = ~cmd[2];
   assign fresh   = !open_q || (open_addr != taddr) || (open_rd != rdir);
   assign last    = (idx + LW'(1)) == len;

   always_comb begin
      op        = LK_STOP;
      lnk_wbyte = '0;
      lnk_mack  = 1'b0;
      case (state)
         S_COND: op = fresh ? LK_START : LK_RSTART;
         S_ADDR: begin
            op        = LK_WRITE;
            lnk_wbyte = {taddr, rdir};
         end
         S_DATA: begin
            op        = rdir ? LK_READ : LK_WRITE;
            lnk_wbyte = wbuf[idx[IW-1:0]];
            lnk_mack  = rdir && !(last && closing);
         end
         default: op = LK_STOP;
      endcase
   end

   assign lnk_op    = op;
   assign lnk_req   = (state == S_COND) || (state == S_ADDR) || (state == S_DATA) || (state == S_STOP);
   assign done      = state == S_DONE;
   assign fail_set  = fail_r;
   assign short_set = short_r;
   assign short_len = idx;
   assign rd_we     = (state == S_DATA) && rdir && lnk_done;
   assign rd_idx    = idx[IW-1:0];
   assign rd_byte   = lnk_rbyte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         idx       <= '0;
         open_q    <= 1'b0;
         open_rd   <= 1'b0;
         open_addr <= '0;
         fail_r    <= 1'b0;
         short_r   <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (send) begin
               fail_r  <= bad;
               short_r <= 1'b0;
               idx     <= '0;
               state   <= bad ? S_DONE : S_COND;
            end
            S_COND: if (lnk_done) state <= S_ADDR;
            S_ADDR: if (lnk_done) begin
               if (lnk_nack) begin
                  fail_r <= 1'b1;
                  state  <= S_STOP;
               end else if (len == '0) begin
                  if (closing) state <= S_STOP;
                  else begin
                     open_q    <= 1'b1;
                     open_addr <= taddr;
                     open_rd   <= rdir;
                     state     <= S_DONE;
                  end
               end else state <= S_DATA;
            end
            S_DATA: if (lnk_done) begin
               if (!rdir && lnk_nack) begin
                  short_r <= 1'b1;
                  state   <= S_STOP;
               end else begin
                  idx <= idx + LW'(1);
                  if (last) begin
                     if (closing) state <= S_STOP;
                     else begin
                        open_q    <= 1'b1;
                        open_addr <= taddr;
                        open_rd   <= rdir;
                        state     <= S_DONE;
                     end
                  end
               end
            end
            S_STOP: if (lnk_done) begin
               open_q <= 1'b0;
               state  <= S_DONE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R12: request fields hold until the link answers
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lnk_req && !lnk_done) |=> (lnk_req && $stable(lnk_op) && $stable(lnk_wbyte)));

   // R7: refused address goes straight to a stop
   a_r7_addr_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_ADDR && lnk_done && lnk_nack) |=> (lnk_req && lnk_op == 3'(LK_STOP)));

   // R8: refused data byte goes straight to a stop
   a_r8_data_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_DATA && !rdir && lnk_done && lnk_nack) |=> (lnk_req && lnk_op == 3'(LK_STOP)));

   // R2: unsupported command never touches the link
   a_r2_bad_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && send && bad) |=> !lnk_req);

endmodule

// File: rtl/i2creq_engine.sv
module i2creq_engine
   import i2creq_pkg::*;
#(
   parameter int NBYTES = 16,
   parameter int AW     = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [AW-1:0] reg_addr,
   input  logic [7:0]    reg_wdata,
   output logic [7:0]    reg_rdata,
   output logic          irq,
   output logic          lnk_req,
   output logic [2:0]    lnk_op,
   output logic [7:0]    lnk_wbyte,
   output logic          lnk_mack,
   input  logic          lnk_done,
   input  logic          lnk_nack,
   input  logic [7:0]    lnk_rbyte
);
   localparam int LW = $clog2(NBYTES+1);
   localparam int IW = $clog2(NBYTES);

   generate
      if (NBYTES < 2 || NBYTES > 16 || (NBYTES & (NBYTES - 1)) != 0) begin : g_bad_nbytes
         $error("NBYTES must be a power of two between 2 and 16");
      end
      if (AW < 6) begin : g_bad_aw
         $error("AW must be at least 6 to reach the received-byte window");
      end
   endgenerate

   logic                   send, done, fail_set, short_set, rd_we;
   logic [3:0]             cmd;
   logic [6:0]             taddr;
   logic [LW-1:0]          len, short_len;
   logic [NBYTES-1:0][7:0] wbuf;
   logic [IW-1:0]          rd_idx;
   logic [7:0]             rd_byte;

   i2creq_regs #(.NBYTES(NBYTES), .AW(AW)) u_regs (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .send, .cmd, .taddr, .len, .wbuf,
      .done, .fail_set, .short_set, .short_len,
      .rd_we, .rd_idx, .rd_byte, .irq
   );

   i2creq_seq #(.NBYTES(NBYTES)) u_seq (
      .clk, .rst_n, .send, .cmd, .taddr, .len, .wbuf,
      .done, .fail_set, .short_set, .short_len,
      .rd_we, .rd_idx, .rd_byte,
      .lnk_req, .lnk_op, .lnk_wbyte, .lnk_mack,
      .lnk_done, .lnk_nack, .lnk_rbyte
   );

endmodule

// File: tb/tb_i2creq_engine.sv
module tb_i2creq_engine;
   logic       clk = 1'b0;
   logic       rst_n, reg_we;
   logic [5:0] reg_addr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic       irq, lnk_req, lnk_mack;
   logic [2:0] lnk_op;
   logic [7:0] lnk_wbyte;
   logic       lnk_done, lnk_nack;
   logic [7:0] lnk_rbyte;

   int checks = 0, errors = 0;

   i2creq_engine dut (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .irq,
      .lnk_req, .lnk_op, .lnk_wbyte, .lnk_mack, .lnk_done, .lnk_nack, .lnk_rbyte
   );

   always #4 clk = ~clk;

   // ---------------- link model ----------------
   int         lg_n = 0, rv_n = 0, w_cnt = 0, dcnt = 0, rb_ctr = 0, hold_err = 0;
   int         lg_op [64];
   logic [7:0] lg_byte [64];
   logic       lg_mack [64];
   logic [7:0] rv [32];
   logic [2:0] cap_op;
   logic [7:0] cap_byte;
   bit         ph_addr = 1'b1, na_addr = 1'b0;
   int         nb_idx = -1;

   initial begin
      lnk_done = 1'b0; lnk_nack = 1'b0; lnk_rbyte = '0;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         lnk_done = 1'b0; w_cnt = 0;
      end else if (lnk_done) begin
         lnk_done = 1'b0; lnk_nack = 1'b0; w_cnt = 0;
      end else if (lnk_req) begin
         if (w_cnt == 0) begin
            cap_op = lnk_op; cap_byte = lnk_wbyte;
         end else if (lnk_op !== cap_op || lnk_wbyte !== cap_byte) hold_err++;
         if (w_cnt >= lg_n % 3) begin
            lnk_nack = 1'b0;
            case (lnk_op)
               3'd0, 3'd1: ph_addr = 1'b1;
               3'd2: if (ph_addr) begin
                  ph_addr = 1'b0; dcnt = 0; lnk_nack = na_addr;
               end else begin
                  lnk_nack = (dcnt == nb_idx); dcnt++;
               end
               3'd3: begin
                  lnk_rbyte = 8'hC3 + 8'(rb_ctr * 29); rb_ctr++;
                  if (rv_n < 32) rv[rv_n] = lnk_rbyte;
                  rv_n++;
               end
               default: ;
            endcase
            if (lg_n < 64) begin
               lg_op[lg_n] = int'(lnk_op); lg_byte[lg_n] = lnk_wbyte; lg_mack[lg_n] = lnk_mack;
            end
            lg_n++;
            lnk_done = 1'b1;
         end else w_cnt++;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_we = 1'b0; reg_addr = a;
      #1 v = reg_rdata;
   endtask

   function automatic logic [7:0] wd(input int i);
      return 8'h5A ^ 8'(i * 8'h11);
   endfunction

   // ---------------- expectation model ----------------
   bit         m_open = 1'b0, m_rd = 1'b0;
   logic [6:0] m_addr = '0;
   int         e_n, e_len;
   int         e_op [64];
   logic [7:0] e_byte [64];
   logic       e_mack [64];
   bit         e_fail, e_short, e_rd, e_sie, e_gie;

   task automatic push(input int o, input logic [7:0] b, input logic m);
      e_op[e_n] = o; e_byte[e_n] = b; e_mack[e_n] = m; e_n++;
   endtask

   task automatic begin_req(input logic [3:0] c, input logic [6:0] a, input int n,
                            input bit sie, input bit gie);
      int  ne;
      bit  closing, fresh, stopped;
      ne = (n > 16) ? 16 : n;
      wr(6'h04, 8'h07);
      wr(6'h00, {4'b0, c});
      wr(6'h01, {1'b0, a});
      wr(6'h02, 8'(n));
      e_n = 0; e_fail = 0; e_short = 0; e_len = ne; e_rd = 0; e_sie = sie; e_gie = gie;
      if (c[3] | c[1]) e_fail = 1;   // R2 unsupported command
      else begin
         closing = !c[2];
         fresh   = !m_open || m_addr != a || m_rd != c[0];
         push(fresh ? 0 : 1, 8'h00, 1'b0);            // R3
         push(2, {a, c[0]}, 1'b0);
         if (na_addr) begin                          // R7
            e_fail = 1; push(4, 8'h00, 1'b0); m_open = 0;
         end else begin
            stopped = 0;
            for (int i = 0; i < ne; i++) begin       // R5
               if (c[0]) push(3, 8'h00, !(i == ne - 1 && closing));
               else begin
                  push(2, wd(i), 1'b0);
                  if (nb_idx == i) begin             // R8
                     e_short = 1; e_len = i; push(4, 8'h00, 1'b0);
                     m_open = 0; stopped = 1; break;
                  end
               end
            end
            e_rd = c[0];
            if (!stopped) begin                      // R6
               if (closing) begin push(4, 8'h00, 1'b0); m_open = 0; end
               else begin m_open = 1; m_addr = a; m_rd = c[0]; end
            end
         end
      end
      lg_n = 0; rv_n = 0; hold_err = 0;
      wr(6'h03, {5'b0, gie, sie, 1'b1});
   endtask

   task automatic end_req();
      logic [7:0] v;
      int t = 0, bad = 0, bi = -1;
      do begin rd(6'h03, v); t++; end while (v[0] && t < 3000);
      chk(t < 3000, "R9 send self-clear", int'(v[0]), 0);
      chk(lg_n == e_n, "R3 link op count", lg_n, e_n);
      for (int i = 0; i < e_n && i < lg_n; i++) begin
         if (lg_op[i] != e_op[i] ||
             (e_op[i] == 2 && lg_byte[i] != e_byte[i]) ||
             (e_op[i] == 3 && lg_mack[i] != e_mack[i])) begin
            bad++; if (bi < 0) bi = i;
         end
      end
      if (bi < 0) bi = 0;
      chk(bad == 0, "R5 R6 link op sequence", lg_op[bi] * 256 + int'(lg_byte[bi]),
          e_op[bi] * 256 + int'(e_byte[bi]));
      chk(hold_err == 0, "R12 request held stable", hold_err, 0);
      rd(6'h04, v);
      chk(v == {5'b0, e_short, e_fail, 1'b1}, "R2 R7 R8 R9 status flags", int'(v),
          int'({5'b0, e_short, e_fail, 1'b1}));
      rd(6'h02, v);
      chk(int'(v) == e_len, "R4 R8 count register", int'(v), e_len);
      chk(irq == (e_sie & e_gie), "R10 irq gating", int'(irq), int'(e_sie & e_gie));
      if (e_rd && !e_fail) begin
         bad = 0;
         for (int i = 0; i < e_len; i++) begin
            rd(6'(32 + i), v);
            if (v != rv[i]) bad++;
         end
         chk(bad == 0, "R5 received bytes stored", bad, 0);
      end
   endtask

   task automatic run_req(input logic [3:0] c, input logic [6:0] a, input int n,
                          input bit sie, input bit gie);
      begin_req(c, a, n, sie, gie);
      end_req();
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(8 * 190000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      logic [7:0] v;
      int chain [5] = '{4, 4, 5, 1, 0};
      reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         rd(6'(a), v);
         chk(v == 8'h00, "R1 register after reset", int'(v), 0);
      end
      chk(irq == 1'b0 && lnk_req == 1'b0, "R1 outputs after reset", int'({irq, lnk_req}), 0);

      for (int i = 0; i < 16; i++) wr(6'(16 + i), wd(i));

      // R3 R5 R6 R10 sweep: every count through an open/close chain
      for (int n = 0; n <= 16; n++)
         for (int k = 0; k < 5; k++)
            run_req(4'(chain[k]), 7'h50, n, bit'((n + k) % 2), bit'(((n + k) / 2) % 2));

      // R3 address change while open forces a fresh start
      run_req(4'h4, 7'h50, 1, 1, 1);
      run_req(4'h4, 7'h30, 2, 1, 1);
      run_req(4'h0, 7'h30, 0, 1, 1);

      // R2 unsupported commands leave the open transaction intact
      run_req(4'h4, 7'h22, 0, 1, 0);
      for (int c = 0; c < 16; c++)
         if (c[3] || c[1]) run_req(4'(c), 7'h22, 3, 1, 1);
      run_req(4'h0, 7'h22, 0, 0, 1);

      // R7 refused address closes the bus
      run_req(4'h4, 7'h40, 0, 1, 1);
      na_addr = 1'b1;
      run_req(4'h5, 7'h40, 4, 1, 1);
      na_addr = 1'b0;
      run_req(4'h1, 7'h40, 1, 1, 1);

      // R8 refused data byte at several positions
      nb_idx = 0;  run_req(4'h4, 7'h41, 8, 1, 0);
      nb_idx = 3;  run_req(4'h4, 7'h41, 8, 1, 0);
      nb_idx = 7;  run_req(4'h0, 7'h41, 8, 1, 0);
      nb_idx = 15; run_req(4'h4, 7'h41, 16, 1, 1);
      nb_idx = -1;

      // R4 count saturation
      wr(6'h02, 8'h25); rd(6'h02, v);
      chk(v == 8'd16, "R4 count saturates", int'(v), 16);
      wr(6'h02, 8'hFF); rd(6'h02, v);
      chk(v == 8'd16, "R4 count saturates at max", int'(v), 16);
      run_req(4'h1, 7'h33, 40, 1, 1);

      // R11 writes while busy are ignored
      begin_req(4'h4, 7'h15, 16, 1, 1);
      wr(6'h00, 8'h01);
      wr(6'h01, 8'h7F);
      wr(6'h02, 8'h02);
      wr(6'h10, 8'hFF);
      end_req();
      rd(6'h00, v); chk(v == 8'h04, "R11 command kept", int'(v), 4);
      rd(6'h01, v); chk(v == 8'h15, "R11 address kept", int'(v), 'h15);
      rd(6'h10, v); chk(v == wd(0), "R11 outgoing byte kept", int'(v), int'(wd(0)));
      run_req(4'h0, 7'h15, 0, 1, 1);

      // R9 R10 write-one-to-clear status
      run_req(4'hA, 7'h15, 0, 1, 1);
      wr(6'h04, 8'h02); rd(6'h04, v);
      chk(v == 8'h01, "R9 failed clears alone", int'(v), 1);
      chk(irq == 1'b1, "R10 irq still set", int'(irq), 1);
      wr(6'h04, 8'h01); rd(6'h04, v);
      chk(v == 8'h00, "R9 completion clears", int'(v), 0);
      chk(irq == 1'b0, "R10 irq drops", int'(irq), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule